// File: doc/BRIEF.md
# Radix-4 Booth Sequential Signed Multiplier

This block multiplies two signed operands of an even width W and returns their full product of 2W bits. It works one cycle per radix-4 digit of the multiplier. Each digit is read from a three-bit window of the multiplier: the two bits of the current pair and the bit just below them, with a zero below the least significant bit. The digit is one of 0, +1, +2, -1 or -2. The block adds that multiple of the multiplicand into an accumulator, then shifts the accumulator right arithmetically by two places. After W/2 such steps the whole product is in place. Operands of either sign go through the same datapath, and no sign correction follows at the end.

The block is driven by plain control pins. A start pulse taken while the block is idle captures both operands. Busy then stays high for the length of the operation, and done rises for one cycle at the moment the product register updates. The data path has no valid/ready handshake. The result is held on the product pins until the next operation finishes, so no back-pressure is needed. The block never stalls, and a consumer reads the product at or after the done pulse. A start seen while busy is dropped and is not queued.

Top module: `booth_r4_mult`

## Requirements
- R1: When done is high, product equals the two's-complement product of the multiplicand and multiplier captured at the accepted start, as a 2W-bit signed value. This holds for all four sign combinations.
- R2: Done is high for exactly one cycle, and exactly W/2 clock cycles after the edge that accepted start. So at most W/2 summands are added per operation.
- R3: Busy rises in the cycle after an accepted start and stays high until the done cycle. It is low while done is high.
- R4: A start that arrives while busy is high is ignored. It does not change the product, the timing of done, or the operation in progress.
- R5: Operands are registered on the accepting edge. Changing the mcand and mplier inputs while busy has no effect on the result.
- R6: Each digit comes from the window {y[2i+1], y[2i], y[2i-1]} with y[-1]=0. The mapping is 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. Multiplier patterns that exercise each code give exact products: for example 30 × 5 = 150, and the operands 0x55 and 0xAA.
- R7: While reset is asserted (active low), busy, done and product are all 0.
- R8: Product keeps its value in every cycle except a done cycle.
- R9: The extreme operands multiply without overflow: (-2^(W-1)) × (-2^(W-1)) = 2^(2W-2), and (-2^(W-1)) × (2^(W-1)-1) is exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only when busy is low |
| mcand | input | WIDTH | Signed multiplicand, captured at accepted start |
| mplier | input | WIDTH | Signed multiplier, captured at accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; product valid from this cycle |
| product | output | 2*WIDTH | Signed product, held until the next done |

## Verification
Timing is counted from the rising edge that samples start while the block is idle. Busy is due one cycle after that edge. Done and the new product are due W/2 cycles after it, which is 4 cycles at the default width. The bench keeps a behavioural model with a countdown and the pending product. The model is updated on the same rising edges as the design and compared at every falling edge, so each output is checked in its due cycle and also held in every cycle in between. The stimulus includes a start held high across a whole operation, extra start pulses in mid-operation, and operand inputs scrambled while busy. The model must then show no restart and no change of operands.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;
  // Radix-4 digit: nz = non-zero, neg = subtract, dbl = use twice the multiplicand
  typedef struct packed {
    logic nz;
    logic neg;
    logic dbl;
  } r4_digit_t;
endpackage

// File: rtl/booth_r4_recode.sv
module booth_r4_recode
  import booth_r4_pkg::*;
(
  input  logic [2:0] win,
  output r4_digit_t  dig
);
  // R6: digit selection from {y[2i+1], y[2i], y[2i-1]}
  always_comb begin
    unique case (win)
      3'b000, 3'b111: dig = '{nz: 1'b0, neg: 1'b0, dbl: 1'b0};
      3'b001, 3'b010: dig = '{nz: 1'b1, neg: 1'b0, dbl: 1'b0};
      3'b011:         dig = '{nz: 1'b1, neg: 1'b0, dbl: 1'b1};
      3'b100:         dig = '{nz: 1'b1, neg: 1'b1, dbl: 1'b1};
      default:        dig = '{nz: 1'b1, neg: 1'b1, dbl: 1'b0};
    endcase
  end
endmodule

// File: rtl/booth_r4_step.sv
module booth_r4_step
  import booth_r4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH+1:0] acc_hi,
  input  logic [WIDTH-1:0] acc_lo,
  input  logic [WIDTH-1:0] mcand,
  input  r4_digit_t        dig,
  output logic [WIDTH+1:0] nxt_hi,
  output logic [WIDTH-1:0] nxt_lo
);
  localparam int HW = WIDTH + 2;

  logic [HW-1:0] m_ext, m_sel, addend, sum;
  logic          cin;

  always_comb begin
    m_ext  = {{2{mcand[WIDTH-1]}}, mcand};
    m_sel  = dig.dbl ? {m_ext[HW-2:0], 1'b0} : m_ext;
    addend = dig.nz ? (dig.neg ? ~m_sel : m_sel) : '0;
    cin    = dig.nz & dig.neg;
    sum    = acc_hi + addend + {{(HW-1){1'b0}}, cin};
    // arithmetic shift of {sum, acc_lo} right by two
    nxt_hi = {{2{sum[HW-1]}}, sum[HW-1:2]};
    nxt_lo = {sum[1:0], acc_lo[WIDTH-1:2]};
  end
endmodule

// File: rtl/booth_r4_ctrl.sv
module booth_r4_ctrl #(
  parameter int STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic last_step
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] STEPS_C = CW'(STEPS);

  logic [CW-1:0] cnt_q;

  assign load      = start && !busy;
  assign last_step = busy && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= last_step;
      if (load) begin
        busy  <= 1'b1;
        cnt_q <= STEPS_C;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // checker-only age counter: cycles since the accepting edge
  logic [CW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      age_q <= '0;
    else if (load)   age_q <= '0;
    else if (busy)   age_q <= age_q + 1'b1;
  end

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_age_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (age_q == STEPS_C));
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_end_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> (busy && age_q == $past(age_q) + 1'b1));
endmodule

// File: rtl/booth_r4_mult.sv
module booth_r4_mult
  import booth_r4_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int STEPS = WIDTH / 2;
  localparam int HW    = WIDTH + 2;

  logic             load, last_step;
  logic [WIDTH-1:0] m_q, lo_q, nxt_lo;
  logic [HW-1:0]    hi_q, nxt_hi;
  logic             g_q;
  logic [2*WIDTH-1:0] product_q;
  r4_digit_t        dig;

  booth_r4_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .load(load), .last_step(last_step)
  );

  booth_r4_recode u_rec (
    .win({lo_q[1:0], g_q}),
    .dig(dig)
  );

  booth_r4_step #(.WIDTH(WIDTH)) u_step (
    .acc_hi(hi_q), .acc_lo(lo_q), .mcand(m_q), .dig(dig),
    .nxt_hi(nxt_hi), .nxt_lo(nxt_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q       <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      g_q       <= 1'b0;
      product_q <= '0;
    end else if (load) begin
      m_q  <= mcand;
      hi_q <= '0;
      lo_q <= mplier;
      g_q  <= 1'b0;
    end else if (busy) begin
      hi_q <= nxt_hi;
      lo_q <= nxt_lo;
      g_q  <= lo_q[1];
      if (last_step) product_q <= {nxt_hi[WIDTH-1:0], nxt_lo};
    end
  end

  assign product = product_q;

  p_mcand_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(m_q));
  p_product_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

// File: tb/booth_r4_mult_tb_top.sv
module booth_r4_mult_tb_top;
  localparam int W = 8;
  localparam int STEPS = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mc = '0, mp = '0;
  logic busy, done;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc = 0;
  string tag = "reset";

  always #5 clk = ~clk;

  booth_r4_mult #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mc), .mplier(mp),
    .busy(busy), .done(done), .product(product)
  );

  // behavioural reference model
  logic m_busy = 1'b0, m_done = 1'b0;
  logic [2*W-1:0] m_prod = '0, m_pend = '0;
  int m_cnt = 0;

  always @(posedge clk) begin
    logic signed [2*W-1:0] ea, eb;
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_prod = m_pend;
        end
      end else if (start) begin
        ea = $signed(mc);
        eb = $signed(mp);
        m_pend = ea * eb;
        m_busy = 1'b1;
        m_cnt = STEPS;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s [%s] cycle %0d: actual=%0h expected=%0h", req, tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 busy", 64'(busy), 64'(m_busy));
      chk("R2 done", 64'(done), 64'(m_done));
      chk(m_done ? "R1 product" : "R8 product hold", 64'(product), 64'(m_prod));
    end
    if (cyc > 100000) begin
      n_fails++;
      $display("FAIL watchdog [%s]: actual=hung expected=finished", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input string t, input bit poke);
    @(negedge clk);
    tag = t; start = 1'b1; mc = a; mp = b;
    @(negedge clk);
    start = 1'b0;
    mc = W'($urandom); mp = W'($urandom);   // R5: inputs change while busy
    if (poke) begin                         // R4: start while busy
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; mc = W'($urandom);
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MPOS = {1'b0, {(W-1){1'b1}}};

  initial begin
    repeat (2) @(negedge clk);
    // R7: reset state
    chk("R7 busy", 64'(busy), 64'(0));
    chk("R7 done", 64'(done), 64'(0));
    chk("R7 product", 64'(product), 64'(0));
    rst_n = 1'b1;

    run_op(W'(5),    W'(30),  "R6 multiplier 30", 1'b0);
    run_op(W'(7),    W'(85),  "R6 pattern 0x55", 1'b0);
    run_op(W'(-3),   W'(170), "R6 pattern 0xAA", 1'b0);
    run_op(W'(13),   W'(11),  "R1 pos x pos", 1'b0);
    run_op(W'(-13),  W'(11),  "R1 neg x pos", 1'b0);
    run_op(W'(13),   W'(-11), "R1 pos x neg", 1'b0);
    run_op(W'(-13),  W'(-11), "R1 neg x neg", 1'b0);
    run_op(W'(0),    W'(-1),  "R1 zero operand", 1'b0);
    run_op(MNEG,     MNEG,    "R9 min x min", 1'b0);
    run_op(MNEG,     MPOS,    "R9 min x max", 1'b0);
    run_op(MPOS,     MPOS,    "R9 max x max", 1'b0);
    run_op(W'(-1),   W'(-1),  "R9 minus one squared", 1'b0);
    run_op(W'(9),    W'(-12), "R4 start pulse while busy", 1'b1);
    run_op(W'(-77),  W'(45),  "R5 inputs scrambled while busy", 1'b0);

    // R4: start held high through two operations
    @(negedge clk);
    tag = "R4 start held high"; start = 1'b1; mc = W'(-6); mp = W'(19);
    repeat (2 * STEPS + 4) @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 300; i++)
      run_op(W'($urandom), W'($urandom), "R1 random", (i % 5) == 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule